// File: doc/BRIEF.md
# Branch redirect and flush controller

This block steers instruction fetch for a five-stage in-order pipeline. Each cycle it picks the next fetch address from four candidates: the sequential address, the predictor's guess, a correction from decode, or a correction from execute. It carries every fetched instruction's prediction into decode and execute. There it compares that prediction with what each stage learns about the branch.

Errors that decode can see are repaired with a short flush. These are a non-branch that was predicted taken, or a direct unconditional jump with a wrong predicted path. A short flush kills only the instruction fetched behind the decoding one. Errors that only execute can see are repaired with a full flush. These are a wrong conditional direction, or a wrong indirect target. A full flush empties the decode and execute slots.

An update port reports every resolved branch back to the predictor. The branch class, the resolved direction and the targets are inputs from surrounding logic.

Top module: `br_redirect_ctrl`

## Requirements
- R1: While reset is held, the fetch address equals the parameter RESET_PC. Both stage-valid outputs are 0, and neither flush output nor the update output is asserted.
- R2: When no flush of either kind occurs and the predictor says not-taken, the next fetch address is the current one plus 4.
- R3: When no flush of either kind occurs and the predictor says taken, the next fetch address is the predictor's target.
- R4: Class codes are 0 for non-branch, 1 for direct unconditional jump, 2 for conditional direct branch and 3 for indirect jump. For a valid decode instruction of class 0 or 1, the resolved next address is PC+4 for class 0 and the decode target for class 1. The predicted next address is the predicted target when predicted taken, else PC+4. If these two differ, short_flush_o rises. The next fetch address is then the resolved address, the fetched instruction is dropped from decode, and the decoding instruction still enters execute.
- R5: For a valid execute instruction, the resolved next address depends on its class. For class 2 it is the decode target when taken, else PC+4. For class 3 it is ex_target_i. If it differs from the predicted next address, flush_o rises. The next fetch address is then the resolved address, and both stage slots are empty in the following cycle.
- R6: A full flush takes priority over a decode correction in the same cycle. short_flush_o stays low and the decode correction is discarded.
- R7: A slot whose valid bit is 0 never raises a flush, a short flush or an update.
- R8: Every valid execute instruction of class 2 or 3 produces an update in that cycle. The update carries its PC and its resolved direction (always 1 for class 3). Its target is the decode target for class 2 (in either direction) and ex_target_i for class 3.
- R9: A valid, unflushed class-1 instruction in decode produces an update with taken=1 and the decode target. If execute produces an update in the same cycle, the jump's update is instead issued when that jump reaches execute.
- R10: Instructions of class 0 or 1 in execute never cause a full flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bp_taken_i | input | 1 | Predictor's taken guess for the current fetch address |
| bp_target_i | input | 32 | Predictor's target for the current fetch address |
| dec_class_i | input | 2 | Branch class of the decode instruction |
| dec_target_i | input | 32 | Target computed at decode for direct branches |
| ex_taken_i | input | 1 | Resolved direction of a conditional in execute |
| ex_target_i | input | 32 | Resolved target of an indirect jump in execute |
| fetch_pc_o | output | 32 | Current fetch address |
| dec_valid_o | output | 1 | Decode slot holds a live instruction |
| dec_pc_o | output | 32 | Address of the decode instruction |
| ex_valid_o | output | 1 | Execute slot holds a live instruction |
| ex_pc_o | output | 32 | Address of the execute instruction |
| short_flush_o | output | 1 | Decode-stage correction this cycle |
| flush_o | output | 1 | Execute-stage correction this cycle |
| upd_valid_o | output | 1 | Predictor update pulse |
| upd_pc_o | output | 32 | Address of the branch being reported |
| upd_taken_o | output | 1 | Reported direction |
| upd_target_o | output | 32 | Reported target |

## Verification
Some properties are checked on every cycle. Full and short flushes never coincide. Each flush restarts fetch at the address its stage resolved. Each flush empties exactly the slots it should. Empty slots never redirect or update.

Other behaviour only the bench's scenarios can show. This covers whether the resolved address itself is right for each class and direction, and the sequential and predicted fetch paths. It also covers the contents of the update port and whether a jump update that was deferred reaches execute with the right fields.

// File: rtl/br_pkg.sv
package br_pkg;
  localparam int unsigned PC_W       = 32;
  localparam int unsigned INSN_BYTES = 4;

  typedef logic [PC_W-1:0] pc_t;

  typedef enum logic [1:0] {
    BR_NONE  = 2'd0,
    BR_JUMP  = 2'd1,
    BR_COND  = 2'd2,
    BR_INDIR = 2'd3
  } br_class_e;

  typedef struct packed {
    logic valid;
    pc_t  pc;
    logic pred_taken;
    pc_t  pred_target;
  } dec_slot_t;

  typedef struct packed {
    logic      valid;
    pc_t       pc;
    logic      pred_taken;
    pc_t       pred_target;
    br_class_e cls;
    pc_t       dir_target;
    logic      upd_owed;
  } ex_slot_t;

  function automatic pc_t seq_pc(pc_t pc);
    return pc + pc_t'(INSN_BYTES);
  endfunction

  function automatic pc_t pred_next(logic taken, pc_t target, pc_t pc);
    return taken ? target : seq_pc(pc);
  endfunction
endpackage

// File: rtl/br_dec_check.sv
module br_dec_check
  import br_pkg::*;
(
  input  dec_slot_t slot_i,
  input  br_class_e cls_i,
  input  pc_t       target_i,
  input  logic      kill_i,
  input  logic      upd_busy_i,
  output logic      redirect_o,
  output pc_t       redirect_pc_o,
  output logic      upd_now_o,
  output logic      upd_defer_o
);
  logic resolves_here;
  logic live_jump;

  assign resolves_here = slot_i.valid && (cls_i == BR_NONE || cls_i == BR_JUMP);
  assign redirect_pc_o = (cls_i == BR_NONE) ? seq_pc(slot_i.pc) : target_i;
  assign redirect_o    = resolves_here && !kill_i &&
                         (redirect_pc_o != pred_next(slot_i.pred_taken, slot_i.pred_target, slot_i.pc));

  assign live_jump   = slot_i.valid && cls_i == BR_JUMP && !kill_i;
  assign upd_now_o   = live_jump && !upd_busy_i;
  assign upd_defer_o = live_jump && upd_busy_i;
endmodule

// File: rtl/br_ex_check.sv
module br_ex_check
  import br_pkg::*;
(
  input  ex_slot_t slot_i,
  input  logic     taken_i,
  input  pc_t      target_i,
  output logic     mispredict_o,
  output pc_t      resolved_pc_o,
  output logic     upd_o,
  output logic     upd_taken_o,
  output pc_t      upd_target_o
);
  logic resolves;

  always_comb begin
    resolves      = 1'b0;
    upd_taken_o   = 1'b1;
    upd_target_o  = slot_i.dir_target;
    resolved_pc_o = seq_pc(slot_i.pc);
    unique case (slot_i.cls)
      BR_COND: begin
        resolves      = slot_i.valid;
        upd_taken_o   = taken_i;
        resolved_pc_o = taken_i ? slot_i.dir_target : seq_pc(slot_i.pc);
      end
      BR_INDIR: begin
        resolves      = slot_i.valid;
        upd_target_o  = target_i;
        resolved_pc_o = target_i;
      end
      BR_JUMP:  resolved_pc_o = slot_i.dir_target;
      default:  upd_taken_o   = 1'b0;
    endcase
  end

  assign mispredict_o = resolves &&
                        (resolved_pc_o != pred_next(slot_i.pred_taken, slot_i.pred_target, slot_i.pc));
  // deferred jump updates drain here, where no other source competes
  assign upd_o = resolves || (slot_i.valid && slot_i.cls == BR_JUMP && slot_i.upd_owed);
endmodule

// File: rtl/br_next_pc.sv
module br_next_pc
  import br_pkg::*;
(
  input  pc_t  pc_i,
  input  logic ex_redirect_i,
  input  pc_t  ex_pc_i,
  input  logic dec_redirect_i,
  input  pc_t  dec_pc_i,
  input  logic bp_taken_i,
  input  pc_t  bp_target_i,
  output pc_t  next_pc_o
);
  always_comb begin
    if (ex_redirect_i)       next_pc_o = ex_pc_i;
    else if (dec_redirect_i) next_pc_o = dec_pc_i;
    else if (bp_taken_i)     next_pc_o = bp_target_i;
    else                     next_pc_o = seq_pc(pc_i);
  end
endmodule

// File: rtl/br_redirect_ctrl.sv
module br_redirect_ctrl
  import br_pkg::*;
#(
  parameter logic [31:0] RESET_PC = 32'h0000_0000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        bp_taken_i,
  input  logic [31:0] bp_target_i,
  input  logic [1:0]  dec_class_i,
  input  logic [31:0] dec_target_i,
  input  logic        ex_taken_i,
  input  logic [31:0] ex_target_i,
  output logic [31:0] fetch_pc_o,
  output logic        dec_valid_o,
  output logic [31:0] dec_pc_o,
  output logic        ex_valid_o,
  output logic [31:0] ex_pc_o,
  output logic        short_flush_o,
  output logic        flush_o,
  output logic        upd_valid_o,
  output logic [31:0] upd_pc_o,
  output logic        upd_taken_o,
  output logic [31:0] upd_target_o
);
  pc_t       pc_q, pc_d;
  dec_slot_t dec_q, dec_d;
  ex_slot_t  ex_q, ex_d;
  br_class_e dec_cls;

  logic ex_flush, ex_upd, ex_upd_taken;
  pc_t  ex_res_pc, ex_upd_target;
  logic dec_redir, dec_upd, dec_defer;
  pc_t  dec_res_pc;

  assign dec_cls = br_class_e'(dec_class_i);

  br_ex_check u_ex_check (
    .slot_i        (ex_q),
    .taken_i       (ex_taken_i),
    .target_i      (ex_target_i),
    .mispredict_o  (ex_flush),
    .resolved_pc_o (ex_res_pc),
    .upd_o         (ex_upd),
    .upd_taken_o   (ex_upd_taken),
    .upd_target_o  (ex_upd_target)
  );

  br_dec_check u_dec_check (
    .slot_i        (dec_q),
    .cls_i         (dec_cls),
    .target_i      (dec_target_i),
    .kill_i        (ex_flush),
    .upd_busy_i    (ex_upd),
    .redirect_o    (dec_redir),
    .redirect_pc_o (dec_res_pc),
    .upd_now_o     (dec_upd),
    .upd_defer_o   (dec_defer)
  );

  br_next_pc u_next_pc (
    .pc_i           (pc_q),
    .ex_redirect_i  (ex_flush),
    .ex_pc_i        (ex_res_pc),
    .dec_redirect_i (dec_redir),
    .dec_pc_i       (dec_res_pc),
    .bp_taken_i     (bp_taken_i),
    .bp_target_i    (bp_target_i),
    .next_pc_o      (pc_d)
  );

  always_comb begin
    dec_d.valid       = !ex_flush && !dec_redir;
    dec_d.pc          = pc_q;
    dec_d.pred_taken  = bp_taken_i;
    dec_d.pred_target = bp_target_i;

    ex_d.valid       = dec_q.valid && !ex_flush;
    ex_d.pc          = dec_q.pc;
    ex_d.pred_taken  = dec_q.pred_taken;
    ex_d.pred_target = dec_q.pred_target;
    ex_d.cls         = dec_cls;
    ex_d.dir_target  = dec_target_i;
    ex_d.upd_owed    = dec_defer;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q  <= RESET_PC;
      dec_q <= '0;
      ex_q  <= '0;
    end else begin
      pc_q  <= pc_d;
      dec_q <= dec_d;
      ex_q  <= ex_d;
    end
  end

  assign fetch_pc_o    = pc_q;
  assign dec_valid_o   = dec_q.valid;
  assign dec_pc_o      = dec_q.pc;
  assign ex_valid_o    = ex_q.valid;
  assign ex_pc_o       = ex_q.pc;
  assign short_flush_o = dec_redir;
  assign flush_o       = ex_flush;
  assign upd_valid_o   = ex_upd || dec_upd;
  assign upd_pc_o      = ex_upd ? ex_q.pc : dec_q.pc;
  assign upd_taken_o   = ex_upd ? ex_upd_taken : 1'b1;
  assign upd_target_o  = ex_upd ? ex_upd_target : dec_target_i;
endmodule

// File: rtl/br_redirect_ctrl_chk.sv
module br_redirect_ctrl_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [31:0] fetch_pc_i,
  input logic        dec_valid_i,
  input logic        ex_valid_i,
  input logic        short_flush_i,
  input logic        flush_i,
  input logic        upd_valid_i,
  input logic [31:0] ex_res_pc_i,
  input logic [31:0] dec_res_pc_i
);
  assert_flush_excl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(flush_i && short_flush_i));

  assert_flush_restart_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> fetch_pc_i == $past(ex_res_pc_i));

  assert_flush_kill_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !dec_valid_i && !ex_valid_i);

  assert_short_restart_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    short_flush_i |=> fetch_pc_i == $past(dec_res_pc_i));

  assert_short_kill_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    short_flush_i |=> !dec_valid_i && ex_valid_i);

  assert_ex_bubble_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ex_valid_i |-> !flush_i);

  assert_dec_bubble_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dec_valid_i |-> !short_flush_i);

  assert_upd_bubble_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_valid_i |-> (ex_valid_i || dec_valid_i));
endmodule

bind br_redirect_ctrl br_redirect_ctrl_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .fetch_pc_i    (fetch_pc_o),
  .dec_valid_i   (dec_valid_o),
  .ex_valid_i    (ex_valid_o),
  .short_flush_i (short_flush_o),
  .flush_i       (flush_o),
  .upd_valid_i   (upd_valid_o),
  .ex_res_pc_i   (ex_res_pc),
  .dec_res_pc_i  (dec_res_pc)
);

// File: tb/br_redirect_ctrl_tb_top.sv
module br_redirect_ctrl_tb_top;
  timeunit 1ns;
  timeprecision 1ps;

  localparam logic [31:0] RST_PC = 32'h0000_0040;
  localparam int NCYC = 3000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bp_taken = 1'b0;
  logic [31:0] bp_target = '0;
  logic [1:0]  dec_class = '0;
  logic [31:0] dec_target = '0;
  logic        ex_taken = 1'b0;
  logic [31:0] ex_target = '0;
  logic [31:0] fetch_pc, dec_pc, ex_pc, upd_pc, upd_target;
  logic        dec_valid, ex_valid, short_flush, flush, upd_valid, upd_taken;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // reference state
  logic [31:0] m_pc, dpc, dptgt, epc, eptgt, edt;
  logic        dv, dpt, ev, ept, edefer;
  logic [1:0]  ecls;
  string       prev_req;

  always #2.5 clk = ~clk;

  br_redirect_ctrl #(.RESET_PC(RST_PC)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .bp_taken_i(bp_taken), .bp_target_i(bp_target),
    .dec_class_i(dec_class), .dec_target_i(dec_target),
    .ex_taken_i(ex_taken), .ex_target_i(ex_target),
    .fetch_pc_o(fetch_pc), .dec_valid_o(dec_valid), .dec_pc_o(dec_pc),
    .ex_valid_o(ex_valid), .ex_pc_o(ex_pc),
    .short_flush_o(short_flush), .flush_o(flush),
    .upd_valid_o(upd_valid), .upd_pc_o(upd_pc),
    .upd_taken_o(upd_taken), .upd_target_o(upd_target)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] pnext(logic t, logic [31:0] tgt, logic [31:0] pc);
    return t ? tgt : pc + 32'd4;
  endfunction

  function automatic logic [31:0] small_pc();
    return 32'h40 + 32'(($urandom % 8) * 4);
  endfunction

  // one cycle: inputs already driven; sample, compare, advance model
  task automatic step();
    logic [31:0] e_res, d_res, nxt, u_pc, u_tgt;
    logic        e_chk, x_flush, d_chk, x_sf, eupd, dupd, dfr, u_tk;
    #1;
    chk(prev_req, "fetch_pc", fetch_pc, m_pc);
    chk(prev_req, "dec_valid", 32'(dec_valid), 32'(dv));
    chk(prev_req, "ex_valid", 32'(ex_valid), 32'(ev));
    if (dv) chk("R2", "dec_pc", dec_pc, dpc);
    if (ev) chk("R2", "ex_pc", ex_pc, epc);

    e_chk = ev && ecls[1];
    case (ecls)
      2'd2:    e_res = ex_taken ? edt : epc + 32'd4;
      2'd3:    e_res = ex_target;
      default: e_res = epc + 32'd4;
    endcase
    x_flush = e_chk && (e_res != pnext(ept, eptgt, epc));
    chk(!ev ? "R7" : (ecls[1] ? "R5" : "R10"), "flush", 32'(flush), 32'(x_flush));

    d_chk = dv && !dec_class[1];
    d_res = (dec_class == 2'd0) ? dpc + 32'd4 : dec_target;
    x_sf  = d_chk && !x_flush && (d_res != pnext(dpt, dptgt, dpc));
    chk(!dv ? "R7" : (x_flush ? "R6" : "R4"), "short_flush", 32'(short_flush), 32'(x_sf));

    eupd = e_chk || (ev && ecls == 2'd1 && edefer);
    dupd = dv && dec_class == 2'd1 && !x_flush && !eupd;
    dfr  = dv && dec_class == 2'd1 && !x_flush && eupd;
    chk(eupd ? "R8" : "R9", "upd_valid", 32'(upd_valid), 32'(eupd || dupd));
    if (eupd) begin
      u_pc  = epc;
      u_tk  = (ecls == 2'd2) ? ex_taken : 1'b1;
      u_tgt = (ecls == 2'd3) ? ex_target : edt;
    end else begin
      u_pc = dpc; u_tk = 1'b1; u_tgt = dec_target;
    end
    if (eupd || dupd) begin
      chk(eupd ? "R8" : "R9", "upd_pc", upd_pc, u_pc);
      chk(eupd ? "R8" : "R9", "upd_taken", 32'(upd_taken), 32'(u_tk));
      chk(eupd ? "R8" : "R9", "upd_target", upd_target, u_tgt);
    end

    nxt = x_flush ? e_res : x_sf ? d_res : bp_taken ? bp_target : m_pc + 32'd4;
    prev_req = x_flush ? "R5" : x_sf ? "R4" : bp_taken ? "R3" : "R2";
    ev = dv && !x_flush; epc = dpc; ept = dpt; eptgt = dptgt;
    ecls = dec_class; edt = dec_target; edefer = dfr;
    dv = !x_flush && !x_sf; dpc = m_pc; dpt = bp_taken; dptgt = bp_target;
    m_pc = nxt;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (2) @(negedge clk);
    // R1 reset state
    chk("R1", "fetch_pc", fetch_pc, RST_PC);
    chk("R1", "dec_valid", 32'(dec_valid), 32'd0);
    chk("R1", "ex_valid", 32'(ex_valid), 32'd0);
    chk("R1", "flush", 32'(flush), 32'd0);
    chk("R1", "short_flush", 32'(short_flush), 32'd0);
    chk("R1", "upd_valid", 32'(upd_valid), 32'd0);

    m_pc = RST_PC; dv = 0; ev = 0; dpc = '0; dpt = 0; dptgt = '0;
    epc = '0; ept = 0; eptgt = '0; ecls = '0; edt = '0; edefer = 0;
    prev_req = "R1";
    rst_n = 1'b1;

    // directed: straight-line code, never predicted (R2)
    for (int i = 0; i < 10; i++) begin
      bp_taken = 0; dec_class = 2'd0; dec_target = '0; ex_taken = 0; ex_target = '0;
      step();
      @(negedge clk);
    end
    // directed: jumps at decode with the predictor always taken to a fixed spot (R3, R4, R9)
    for (int i = 0; i < 12; i++) begin
      bp_taken = 1; bp_target = 32'h80; dec_class = 2'd1;
      dec_target = (i % 3 == 0) ? 32'h80 : 32'h90;
      step();
      @(negedge clk);
    end
    // directed: conditionals and jumps alternating so execute and decode updates collide (R9, R6)
    for (int i = 0; i < 16; i++) begin
      bp_taken = i[0]; bp_target = 32'h60; dec_class = i[0] ? 2'd2 : 2'd1;
      dec_target = 32'h60; ex_taken = i[1]; ex_target = 32'h44;
      step();
      @(negedge clk);
    end
    // constrained random
    for (int i = 0; i < NCYC; i++) begin
      bp_taken   = ($urandom % 3) == 0;
      bp_target  = small_pc();
      dec_class  = 2'($urandom % 4);
      dec_target = small_pc();
      ex_taken   = 1'($urandom % 2);
      ex_target  = small_pc();
      step();
      @(negedge clk);
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R1 watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule